// File: doc/BRIEF.md
# Scan-Synchronized Frame Transfer Trigger

This block decides when a frame transfer toward a display panel may begin, and it tracks that transfer until it finishes. Software loads a pixel count (the frame's width times height) and then raises an enable. The start can come from a software request, or it can be tied to the panel's scan so that new pixels never overtake the line being refreshed. In that second case the block follows the panel's sync outputs, counts scan lines since the last frame sync, and fires the start on the horizontal sync of a chosen line.

The panel reports its scan in one of two ways. With two pins, one pin carries horizontal pulses and the other carries vertical pulses. With one pin, both kinds of pulse share the same wire, and the block tells them apart by how long each pulse is active. Once a transfer starts, the bus side sends one done strobe per pixel. When the last pixel is counted, the block raises a one-cycle interrupt. Software must then drop the enable before another transfer can be armed. No pixel data passes through the block: every pin is a plain control or status line, so there is no valid/ready handshake and no back-pressure.

Top module: `scan_sync_trigger`

## Requirements
- R1: After reset, `start_pulse`, `busy`, `done_irq` and `kick_pending` are all 0.
- R2: With `cfg_mode` = 0 (software trigger), or the unused code 3, an armed block issues `start_pulse` once a `ctl_kick` request is pending. Taking that start clears `kick_pending` in the same cycle that `start_pulse` goes high.
- R3: With `cfg_mode` = 2 (two pins), an active pulse on `sync_b` lasting at least `cfg_vwidth` cycles resets the line count to 0. Each active pulse on `sync_a` lasting at least `cfg_hwidth` cycles is one horizontal event. An armed block starts on the horizontal event that occurs while the line count equals `cfg_line`, so `cfg_line` = N starts on the (N+1)-th horizontal pulse after a frame sync.
- R4: With `cfg_mode` = 1 (one pin), all pulses arrive on `sync_a`. A pulse at least `cfg_vwidth` long is a frame sync. A shorter pulse that is at least `cfg_hwidth` long is a horizontal event.
- R5: A pulse shorter than the width required for its kind neither advances nor resets the line count.
- R6: `cfg_hpol` sets the active level of `sync_a` and `cfg_vpol` sets that of `sync_b`; 1 means active high and 0 means active low. Pulse length is measured in clock cycles at the active level.
- R7: `busy` rises together with `start_pulse`. `done_irq` pulses for one cycle in the cycle that `busy` falls, after exactly `cfg_pixels` `pix_done` strobes have been counted.
- R8: Changes to `ctl_enable` while `busy` is high are ignored: no second start occurs, and the pixel count is not reloaded.
- R9: After a completed transfer, no new transfer is armed until `ctl_enable` has been seen low.
- R10: Dropping `ctl_enable` while armed and not yet started cancels the trigger, and no start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; one tick of pulse measurement |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Trigger source: 0 software, 1 one-pin sync, 2 two-pin sync |
| cfg_hpol | input | 1 | Active level of sync_a (1 = high) |
| cfg_vpol | input | 1 | Active level of sync_b (1 = high) |
| cfg_hwidth | input | WIDTH_W | Minimum horizontal pulse length in cycles (at least 2) |
| cfg_vwidth | input | WIDTH_W | Minimum vertical pulse length in cycles, different from cfg_hwidth |
| cfg_line | input | 11 | Line whose horizontal event releases the start |
| cfg_pixels | input | PIX_W | Pixels in the transfer |
| ctl_enable | input | 1 | Arms a transfer |
| ctl_kick | input | 1 | One-cycle software start request |
| sync_a | input | 1 | Horizontal sync, or combined sync in one-pin mode |
| sync_b | input | 1 | Vertical sync in two-pin mode |
| pix_done | input | 1 | One strobe per pixel sent by the bus side |
| start_pulse | output | 1 | One-cycle transfer start |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle end-of-transfer interrupt |
| kick_pending | output | 1 | Software start request not yet taken |

## Verification
The hardest case to reach is one-pin mode. There, the start depends on pulse length alone: a glitch, a horizontal pulse and a frame sync all arrive on the same wire, and only one exact horizontal pulse may release the start. The stimulus drives frame syncs on that pin, then horizontal pulses interleaved with pulses just below `cfg_hwidth`, in both polarities. A scoreboard queue holds the horizontal-pulse index at which each start is expected and the pixel count at which each interrupt is expected. Any early, late or extra start is therefore reported. The bench also toggles the enable during a transfer, and holds it high after completion, to reach the two ignore rules.

// File: rtl/scan_sync_pkg.sv
package scan_sync_pkg;
  localparam int LINE_W = 11;

  typedef enum logic [1:0] {
    TRIG_SOFT    = 2'd0,
    TRIG_ONE_PIN = 2'd1,
    TRIG_TWO_PIN = 2'd2,
    TRIG_RSVD    = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/scan_pulse_meter.sv
module scan_pulse_meter #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin,
  input  logic               active_high,
  output logic               end_stb,
  output logic [WIDTH_W-1:0] len
);
  localparam logic [WIDTH_W-1:0] LEN_MAX = '1;

  logic meta_q, sync_q, act_d;
  logic active;
  logic [WIDTH_W-1:0] cnt_q;

  // two-stage synchronizer for the asynchronous panel pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
    end
  end

  assign active = active_high ? sync_q : ~sync_q;

  // count cycles at the active level, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_d <= active;
      if (!active)
        cnt_q <= '0;
      else if (cnt_q != LEN_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // the pulse ends in the first inactive cycle; cnt_q then holds its length
  assign end_stb = act_d & ~active;
  assign len     = cnt_q;
endmodule

// File: rtl/scan_line_tracker.sv
module scan_line_tracker
  import scan_sync_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [WIDTH_W-1:0] cfg_hwidth,
  input  logic [WIDTH_W-1:0] cfg_vwidth,
  input  logic [LINE_W-1:0]  cfg_line,
  input  logic               a_end,
  input  logic [WIDTH_W-1:0] a_len,
  input  logic               b_end,
  input  logic [WIDTH_W-1:0] b_len,
  output logic               h_evt,
  output logic               v_evt,
  output logic               line_hit
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q;

  always_comb begin
    h_evt = 1'b0;
    v_evt = 1'b0;
    unique case (trig_mode_e'(cfg_mode))
      TRIG_ONE_PIN: begin
        // one wire: the longer class wins, runts are dropped
        if (a_end && a_len >= cfg_vwidth)
          v_evt = 1'b1;
        else if (a_end && a_len >= cfg_hwidth)
          h_evt = 1'b1;
      end
      TRIG_TWO_PIN: begin
        h_evt = a_end && (a_len >= cfg_hwidth);
        v_evt = b_end && (b_len >= cfg_vwidth);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_q <= '0;
    else if (v_evt)
      line_q <= '0;
    else if (h_evt && line_q != LINE_MAX)
      line_q <= line_q + 1'b1;
  end

  assign line_hit = h_evt && !v_evt && (line_q == cfg_line);
endmodule

// File: rtl/scan_xfer_ctrl.sv
module scan_xfer_ctrl
  import scan_sync_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [PIX_W-1:0] cfg_pixels,
  input  logic             ctl_enable,
  input  logic             ctl_kick,
  input  logic             line_hit,
  input  logic             pix_done,
  output logic             start_pulse,
  output logic             busy,
  output logic             done_irq,
  output logic             kick_pending
);
  xfer_state_e      state_q;
  logic             need_clear_q;
  logic             kick_q;
  logic [PIX_W-1:0] remain_q;
  logic             soft_mode;
  logic             fire;
  logic             last_pix;

  assign soft_mode = (cfg_mode == TRIG_SOFT) || (cfg_mode == TRIG_RSVD);
  assign fire      = soft_mode ? kick_q : line_hit;
  assign last_pix  = (remain_q == '0) || (pix_done && remain_q == PIX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      need_clear_q <= 1'b0;
      kick_q       <= 1'b0;
      remain_q     <= '0;
      start_pulse  <= 1'b0;
      done_irq     <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      done_irq    <= 1'b0;
      if (ctl_kick)
        kick_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (!ctl_enable)
            need_clear_q <= 1'b0;
          else if (!need_clear_q)
            state_q <= ST_ARMED;
        end
        ST_ARMED: begin
          if (!ctl_enable)
            state_q <= ST_IDLE;
          else if (fire) begin
            start_pulse <= 1'b1;
            remain_q    <= cfg_pixels;
            state_q     <= ST_ACTIVE;
            if (soft_mode)
              kick_q <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          // the enable is not looked at here
          if (last_pix) begin
            done_irq     <= 1'b1;
            need_clear_q <= 1'b1;
            state_q      <= ST_IDLE;
          end else if (pix_done)
            remain_q <= remain_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state_q == ST_ACTIVE);
  assign kick_pending = kick_q;
endmodule

// File: rtl/scan_sync_trigger.sv
module scan_sync_trigger
  import scan_sync_pkg::*;
#(
  parameter int WIDTH_W = 8,
  parameter int PIX_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_hpol,
  input  logic               cfg_vpol,
  input  logic [WIDTH_W-1:0] cfg_hwidth,
  input  logic [WIDTH_W-1:0] cfg_vwidth,
  input  logic [10:0]        cfg_line,
  input  logic [PIX_W-1:0]   cfg_pixels,
  input  logic               ctl_enable,
  input  logic               ctl_kick,
  input  logic               sync_a,
  input  logic               sync_b,
  input  logic               pix_done,
  output logic               start_pulse,
  output logic               busy,
  output logic               done_irq,
  output logic               kick_pending
);
  logic               a_end, b_end;
  logic [WIDTH_W-1:0] a_len, b_len;
  logic               h_evt, v_evt, line_hit;

  scan_pulse_meter #(.WIDTH_W(WIDTH_W)) u_meter_a (
    .clk(clk), .rst_n(rst_n), .pin(sync_a), .active_high(cfg_hpol),
    .end_stb(a_end), .len(a_len)
  );

  scan_pulse_meter #(.WIDTH_W(WIDTH_W)) u_meter_b (
    .clk(clk), .rst_n(rst_n), .pin(sync_b), .active_high(cfg_vpol),
    .end_stb(b_end), .len(b_len)
  );

  scan_line_tracker #(.WIDTH_W(WIDTH_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_hwidth(cfg_hwidth), .cfg_vwidth(cfg_vwidth), .cfg_line(cfg_line),
    .a_end(a_end), .a_len(a_len), .b_end(b_end), .b_len(b_len),
    .h_evt(h_evt), .v_evt(v_evt), .line_hit(line_hit)
  );

  scan_xfer_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pixels(cfg_pixels),
    .ctl_enable(ctl_enable), .ctl_kick(ctl_kick), .line_hit(line_hit),
    .pix_done(pix_done), .start_pulse(start_pulse), .busy(busy),
    .done_irq(done_irq), .kick_pending(kick_pending)
  );
endmodule

// File: rtl/scan_sync_trigger_sva.sv
module scan_sync_trigger_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       start_pulse,
  input logic       busy,
  input logic       done_irq,
  input logic       kick_pending,
  input logic       h_evt,
  input logic       v_evt,
  input logic       line_hit
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!start_pulse && !busy && !done_irq && !kick_pending));

  assert_kick_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && (cfg_mode == 2'd0 || cfg_mode == 2'd3)) |-> !kick_pending);

  assert_start_on_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && (cfg_mode == 2'd1 || cfg_mode == 2'd2)) |-> $past(line_hit));

  assert_one_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1) |-> !(h_evt && v_evt));

  assert_busy_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (busy && $rose(busy)));

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> ($fell(busy) && !start_pulse));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

bind scan_sync_trigger scan_sync_trigger_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .start_pulse(start_pulse),
  .busy(busy), .done_irq(done_irq), .kick_pending(kick_pending),
  .h_evt(h_evt), .v_evt(v_evt), .line_hit(line_hit)
);

// File: tb/scan_sync_trigger_test.sv
module scan_sync_trigger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_hpol = 1'b1, cfg_vpol = 1'b1;
  logic [7:0]  cfg_hwidth = 8'd3, cfg_vwidth = 8'd5;
  logic [10:0] cfg_line = '0;
  logic [23:0] cfg_pixels = '0;
  logic        ctl_enable = 1'b0, ctl_kick = 1'b0, pix_done = 1'b0;
  logic        a_act = 1'b0, b_act = 1'b0;
  logic        sync_a, sync_b;
  logic        start_pulse, busy, done_irq, kick_pending;

  int checks = 0, fails = 0;
  int h_cnt = 0, pix_sent = 0;
  int exp_start_q[$];
  int exp_done_q[$];

  always #2 clk = ~clk;

  assign sync_a = cfg_hpol ? a_act : ~a_act;
  assign sync_b = cfg_vpol ? b_act : ~b_act;

  scan_sync_trigger uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_hpol(cfg_hpol),
    .cfg_vpol(cfg_vpol), .cfg_hwidth(cfg_hwidth), .cfg_vwidth(cfg_vwidth),
    .cfg_line(cfg_line), .cfg_pixels(cfg_pixels), .ctl_enable(ctl_enable),
    .ctl_kick(ctl_kick), .sync_a(sync_a), .sync_b(sync_b), .pix_done(pix_done),
    .start_pulse(start_pulse), .busy(busy), .done_irq(done_irq),
    .kick_pending(kick_pending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 glitch, 1 horizontal, 2 vertical; on_b selects the second pin
  task automatic pulse(input bit on_b, input int len, input int kind);
    @(negedge clk);
    if (on_b) b_act = 1'b1; else a_act = 1'b1;
    idle(len);
    if (on_b) b_act = 1'b0; else a_act = 1'b0;
    if (kind == 1) h_cnt++;
    if (kind == 2) h_cnt = 0;
    idle(10);
  endtask

  task automatic send_pixels(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_done = 1'b1;
      pix_sent++;
      @(negedge clk);
      pix_done = 1'b0;
    end
  endtask

  task automatic kick();
    @(negedge clk);
    ctl_kick = 1'b1;
    @(negedge clk);
    ctl_kick = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && start_pulse) begin
      if (exp_start_q.size() == 0)
        check(1'b0, "R3/R8 unexpected start", 1, 0);
      else begin
        int e;
        e = exp_start_q.pop_front();
        if (e >= 0) check(h_cnt == e, "R3/R4 start line", h_cnt, e);
        else        check(1'b1, "R2 start", 1, 1);
      end
      pix_sent = 0;
    end
    if (rst_n && done_irq) begin
      if (exp_done_q.size() == 0)
        check(1'b0, "R7 unexpected done", 1, 0);
      else begin
        int e;
        e = exp_done_q.pop_front();
        check(pix_sent == e, "R7 pixel count at done", pix_sent, e);
      end
    end
  end

  task automatic finish_run();
    check(exp_start_q.size() == 0, "R3 missing start", exp_start_q.size(), 0);
    check(exp_done_q.size() == 0, "R7 missing done", exp_done_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    idle(3);
    // R1 reset state
    check(!start_pulse && !busy && !done_irq && !kick_pending, "R1 reset outputs",
          {start_pulse, busy, done_irq, kick_pending}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 software trigger, R8 enable toggled while busy
    cfg_mode = 2'd0; cfg_pixels = 24'd5;
    exp_start_q.push_back(-1); exp_done_q.push_back(5);
    @(negedge clk); ctl_enable = 1'b1;
    kick();
    idle(3);
    check(busy, "R7 busy after start", busy, 1);
    check(!kick_pending, "R2 kick cleared", kick_pending, 0);
    send_pixels(2);
    ctl_enable = 1'b0; idle(2); ctl_enable = 1'b1;  // R8
    send_pixels(2);
    idle(2);
    check(busy, "R7 busy before last pixel", busy, 1);
    send_pixels(1);
    idle(2);
    check(!busy, "R7 idle after done", busy, 0);

    // R9 enable held high: no rearm
    kick();
    idle(20);
    check(!busy && kick_pending, "R9 no rearm while enable held", busy, 0);
    cfg_pixels = 24'd3;
    exp_start_q.push_back(-1); exp_done_q.push_back(3);
    ctl_enable = 1'b0; idle(2); ctl_enable = 1'b1;
    idle(4);
    check(busy && !kick_pending, "R9 rearm after enable low", busy, 1);
    send_pixels(3);
    idle(2);
    ctl_enable = 1'b0; idle(2);

    // R3 two-pin, R5 glitches, R6 active-low vertical
    cfg_mode = 2'd2; cfg_hpol = 1'b1; cfg_vpol = 1'b0;
    cfg_hwidth = 8'd3; cfg_vwidth = 8'd5; cfg_line = 11'd2; cfg_pixels = 24'd4;
    idle(4);
    pulse(1'b0, 4, 1);       // line counted before arming
    pulse(1'b1, 6, 2);       // frame sync
    pulse(1'b1, 3, 0);       // short vertical: no reset (R5)
    @(negedge clk); ctl_enable = 1'b1;
    exp_start_q.push_back(3); exp_done_q.push_back(4);
    pulse(1'b0, 4, 1);
    pulse(1'b0, 2, 0);       // runt (R5)
    pulse(1'b0, 3, 1);
    pulse(1'b0, 1, 0);
    check(!busy, "R3 no early start", busy, 0);
    pulse(1'b0, 5, 1);       // third horizontal -> line 2
    check(busy, "R3 started on line", busy, 1);
    pulse(1'b0, 4, 1);       // ignored while busy (R8)
    send_pixels(4);
    idle(2);
    ctl_enable = 1'b0; idle(2);

    // R4 one-pin, R6 active-low combined pin
    cfg_mode = 2'd1; cfg_hpol = 1'b0; cfg_vpol = 1'b1;
    cfg_hwidth = 8'd2; cfg_vwidth = 8'd6; cfg_line = 11'd3; cfg_pixels = 24'd2;
    idle(4);
    pulse(1'b0, 7, 2);
    @(negedge clk); ctl_enable = 1'b1;
    exp_start_q.push_back(4); exp_done_q.push_back(2);
    pulse(1'b0, 3, 1);
    pulse(1'b0, 1, 0);
    pulse(1'b0, 5, 1);       // just below vertical width
    pulse(1'b0, 2, 1);
    check(!busy, "R4 no start before line 3", busy, 0);
    pulse(1'b0, 4, 1);
    check(busy, "R4 started on line 3", busy, 1);
    send_pixels(2);
    idle(2);
    ctl_enable = 1'b0; idle(2);

    // R4 line 0 right after a long pulse that resets the count mid-frame
    cfg_line = 11'd0; cfg_pixels = 24'd1;
    pulse(1'b0, 3, 1);
    pulse(1'b0, 6, 2);
    @(negedge clk); ctl_enable = 1'b1;
    exp_start_q.push_back(1); exp_done_q.push_back(1);
    pulse(1'b0, 3, 1);
    check(busy, "R4 line 0 start", busy, 1);
    send_pixels(1);
    idle(2);
    ctl_enable = 1'b0; idle(2);

    // R10 cancel while armed
    cfg_mode = 2'd2; cfg_hpol = 1'b1; cfg_vpol = 1'b1;
    cfg_hwidth = 8'd3; cfg_vwidth = 8'd5; cfg_line = 11'd1;
    pulse(1'b1, 6, 2);
    @(negedge clk); ctl_enable = 1'b1;
    idle(3);
    ctl_enable = 1'b0;
    pulse(1'b0, 4, 1);
    pulse(1'b0, 4, 1);
    pulse(1'b0, 4, 1);
    check(!busy, "R10 no start after cancel", busy, 0);

    idle(5);
    finish_run();
  end
endmodule